// File: doc/BRIEF.md
# Watchdog Timer with Write Unlock

The block supervises software by counting pulses of a slow timebase (nominally a 32.768 kHz clock, brought into the system clock domain as a single-cycle strobe `tick_i`). Once software turns it on, the count must be restarted by a protected register write before the selected period runs out. If the period runs out, the block records a timeout flag. It then either requests a system reset or, when programmed for it, raises an interrupt instead.

All control goes through one 8-bit register. The register accepts a configuration write only as the bus write that directly follows a write with the key bit (bit 7) set. That follow-up write consumes the unlock whether or not it changes anything. A locked write that does not carry the key bit is dropped. Rewriting the register through this sequence with the enable bit set restarts the count, and this is the refresh operation.

The register layout, which the bench depends on, is: bits [3:0] timeout code; bit 4 response select (1 = interrupt, 0 = reset); bit 5 timeout flag; bit 6 enable; bit 7 key/unlock pending. The period for code n (0..7) is 2^(BASE_LOG2+n) ticks. The default BASE_LOG2 of 9 gives 512·2^n ticks, which is 15.6 ms to 2 s at 32.768 kHz. Codes 8 and above are treated as a zero period.

Top module: `wdt_core`

## Requirements
- R1: After reset, `rd_data_o` reads 0x00 (code 0, reset response, flag clear, disabled, locked) and `rst_req_o` and `irq_o` are low.
- R2: `rd_data_o` always presents the register as {key pending [7], enable [6], flag [5], response select [4], code [3:0]}.
- R3: A bus write made while locked with bit 7 clear changes no register bit and arms nothing.
- R4: A bus write made while locked with bit 7 set only arms the unlock (bit 7 reads 1). The next bus write is applied to code, response select and enable, whatever its bit 7 is, and leaves the unlock cleared.
- R5: With enable set, code n ≤ 7 and reset response, the tick that completes 2^(BASE_LOG2+n) ticks after the last restart causes a one-cycle `rst_req_o` pulse in the following clock cycle.
- R6: With enable set and code 8, an expiry occurs in every cycle from the first cycle after the enabling write, so `rst_req_o` is high from the second edge after that write.
- R7: Codes 9 to 15 behave exactly like code 8.
- R8: With response select set, an expiry never pulses `rst_req_o`; `irq_o` is high whenever the flag is set and response select is 1.
- R9: Every expiry sets the flag. A protected write with bit 5 = 0 clears it. A protected write with bit 5 = 1 leaves it unchanged.
- R10: A protected write restarts the count from zero. If it falls in the same cycle as the terminal tick, the restart wins and no expiry occurs.
- R11: With enable clear, no expiry occurs and the count is held at zero.
- R12: After an expiry the count restarts, so an unserviced watchdog expires again every full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per timebase period |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| rst_req_o | output | 1 | Reset request pulse on expiry |
| irq_o | output | 1 | Interrupt level in interrupt-response mode |

## Verification
The refresh write and the terminal tick of the period can fall in the same cycle. In that case the restart must suppress the expiry. The bench arms the unlock so that the protected write lands exactly on the edge where the count sits at its last value with the tick high. It then judges the result from the absence of any reset pulse and from the next expiry arriving a full period after that write. The per-cycle reference model independently covers the same collision wherever random tick spacing produces it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W    = 8;
  localparam int CODE_W   = 4;
  localparam int MODE_BIT = 4;
  localparam int FLAG_BIT = 5;
  localparam int EN_BIT   = 6;
  localparam int KEY_BIT  = 7;
  localparam int MAX_FINITE_CODE = 7;

  typedef struct packed {
    logic              en;
    logic              irq_mode;
    logic [CODE_W-1:0] code;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_unlock_seq.sv
module wdt_unlock_seq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output wdt_cfg_t         cfg_o,
  output logic             key_o,
  output logic             load_o,
  output logic             clr_flag_o
);
  wdt_cfg_t cfg_q;
  logic     key_q;

  assign load_o     = wr_en_i && key_q;
  assign clr_flag_o = load_o && !wr_data_i[FLAG_BIT];
  assign cfg_o      = cfg_q;
  assign key_o      = key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      key_q <= 1'b0;
    end else if (wr_en_i) begin
      if (key_q) begin
        cfg_q.code     <= wr_data_i[CODE_W-1:0];
        cfg_q.irq_mode <= wr_data_i[MODE_BIT];
        cfg_q.en       <= wr_data_i[EN_BIT];
        key_q          <= 1'b0;
      end else if (wr_data_i[KEY_BIT]) begin
        key_q <= 1'b1;
      end
    end
  end

  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !key_q && !wr_data_i[KEY_BIT]) |=> ($stable(cfg_q) && !key_q));
  assert_unlock_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && key_q) |=> !key_q);
endmodule

// File: rtl/wdt_period_decode.sv
module wdt_period_decode
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  localparam int CW = BASE_LOG2 + MAX_FINITE_CODE + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CW-1:0]     last_o,
  output logic              immediate_o
);
  logic [CW-1:0] one_hot;

  always_comb begin
    one_hot = '0;
    for (int k = 0; k <= MAX_FINITE_CODE; k++) begin
      if (code_i == CODE_W'(k)) one_hot[BASE_LOG2 + k] = 1'b1;
    end
    immediate_o = (code_i > CODE_W'(MAX_FINITE_CODE));
    last_o      = immediate_o ? '0 : one_hot - CW'(1);
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic          immediate_i,
  input  logic [CW-1:0] last_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !restart_i &&
                    (immediate_i || (tick_i && cnt_q == last_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart_i || !run_i || expire_o) cnt_q <= '0;
    else if (tick_i)                     cnt_q <= cnt_q + CW'(1);
  end

  assert_no_expire_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !expire_o);
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
  assert_wrap_after_expiry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  localparam int CW = BASE_LOG2 + MAX_FINITE_CODE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  wdt_cfg_t      cfg;
  logic          key, load, clr_flag, immediate, expire;
  logic [CW-1:0] last;
  logic          flag_q, rst_req_q;

  wdt_unlock_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cfg_o(cfg), .key_o(key), .load_o(load), .clr_flag_o(clr_flag));

  wdt_period_decode #(.BASE_LOG2(BASE_LOG2)) u_dec (
    .code_i(cfg.code), .last_o(last), .immediate_o(immediate));

  wdt_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(cfg.en), .restart_i(load),
    .tick_i(tick_i), .immediate_i(immediate), .last_i(last), .expire_o(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire && !cfg.irq_mode;
      if (expire)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign rd_data_o = {key, cfg.en, flag_q, cfg.irq_mode, cfg.code};
  assign rst_req_o = rst_req_q;
  assign irq_o     = flag_q && cfg.irq_mode;

  assert_irq_mode_no_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.irq_mode |=> !rst_req_o);
  assert_flag_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  assert_reset_follows_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg.irq_mode) |=> rst_req_o);
endmodule

// File: tb/wdt_core_bench.sv
module wdt_core_bench;
  localparam int BASE = 4;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rst_req, irq;
  int n_tests = 0, n_fail = 0, cyc = 0, tick_div = 1;

  always #4 clk = ~clk;

  wdt_core #(.BASE_LOG2(BASE)) u_wdt_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rst_req_o(rst_req), .irq_o(irq));

  // behavioural reference model
  int m_code, m_mode, m_en, m_flag, m_key, m_cnt, m_rst;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_mode = 0; m_en = 0; m_flag = 0; m_key = 0; m_cnt = 0; m_rst = 0;
    end else begin
      int lim; bit ld, ex;
      lim = 1 << (BASE + (m_code & 7));
      ld = wr_en && m_key;
      ex = m_en && !ld && (m_code >= 8 || (tick && m_cnt == lim - 1));
      m_rst = ex && !m_mode;
      if (ex) m_flag = 1;
      if (ld || !m_en || ex) m_cnt = 0; else if (tick) m_cnt++;
      if (wr_en) begin
        if (m_key) begin
          m_code = wr_data[3:0]; m_mode = wr_data[4]; m_en = wr_data[6];
          if (!wr_data[5]) m_flag = 0;
          m_key = 0;
        end else if (wr_data[7]) m_key = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick <= (tick_div == 1) ? 1'b1 : (cyc % tick_div == 0);
    if (rst_n) begin
      chk("R2 model rd_data", rd_data, {m_key[0], m_en[0], m_flag[0], m_mode[0], m_code[3:0]});
      chk("R5 model rst_req", rst_req, m_rst);
      chk("R8 model irq", irq, m_flag && m_mode);
    end
  end

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic prot_write(input logic [7:0] d);
    bus_write(8'h80); bus_write(d);
  endtask

  task automatic cycles_to(input bit use_irq, input int exp, input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (!(use_irq ? irq : rst_req) && n < 5000);
    chk(tag, n, exp);
  endtask

  initial begin
    #100000000;
    n_fail++; $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset rst_req", rst_req, 0);
    chk("R1 reset irq", irq, 0);
    bus_write(8'h4F);
    chk("R3 locked write ignored", rd_data, 8'h00);
    bus_write(8'h80);
    chk("R4 key armed", rd_data, 8'h80);
    bus_write(8'h40);
    chk("R4 protected write applied", rd_data, 8'h40);
    cycles_to(0, 16, "R5 code0 period");
    @(negedge clk);
    chk("R5 pulse one cycle", rst_req, 0);
    chk("R9 flag set", rd_data, 8'h60);
    cycles_to(0, 15, "R12 periodic re-expiry");
    // refresh racing terminal tick
    prot_write(8'h40);
    repeat (12) @(negedge clk);
    bus_write(8'h80);
    bus_write(8'h40);
    chk("R10 refresh beats terminal tick", rst_req, 0);
    cycles_to(0, 16, "R10 full period after refresh");
    // code 1 with sparse ticks
    tick_div = 3;
    prot_write(8'h41);
    repeat (200) @(negedge clk);
    tick_div = 1;
    // interrupt response
    prot_write(8'h50);
    cycles_to(1, 16, "R8 irq after period");
    chk("R8 no reset in irq mode", rst_req, 0);
    prot_write(8'h70);
    chk("R9 flag kept by bit5=1", rd_data, 8'h70);
    chk("R9 irq still high", irq, 1);
    prot_write(8'h50);
    chk("R9 flag cleared", irq, 0);
    // disabled
    prot_write(8'h00);
    repeat (100) @(negedge clk);
    chk("R11 disabled no expiry", rd_data, 8'h00);
    // immediate code
    prot_write(8'h48);
    chk("R6 not yet", rst_req, 0);
    @(negedge clk);
    chk("R6 immediate reset", rst_req, 1);
    prot_write(8'h00);
    prot_write(8'h4B);
    @(negedge clk);
    chk("R7 reserved code acts as 8", rst_req, 1);
    @(negedge clk);
    chk("R7 reserved code repeats", rst_req, 1);
    prot_write(8'h00);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule